// File: doc/BRIEF.md
# Sequential-Switching Hybrid Gate Mapper

This block drives the four switches of every H-bridge cell in a cascaded multilevel inverter. It combines three things. The first is the sign of the sinusoidal reference, which serves as the fundamental square wave. The second is a sequencing square wave, built inside the block, that runs at half the fundamental frequency. The third is each cell's own carrier-comparison PWM bit. In every cell, one leg switches at carrier rate and the other leg switches only at the reference zero crossings. The two legs swap roles once per fundamental period, so the four devices of a cell share the switching work evenly.

The sequencing wave flips on each rising zero crossing of the reference, which is a clock where the sign input is high after being low. After reset every gate is held off until the first fundamental-period strobe arrives. The gate pattern is a purely combinational function of the sequencing wave, the reference sign and the PWM bits. The voltage level that a cell produces is therefore the same in both sequencing phases. The PWM input is unipolar: in the positive half cycle a 1 asks for +V, and in the negative half cycle a 0 asks for -V.

Top module: `hybrid_mod_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until the first clock edge that samples `period_stb_i` high, every bit of `gate_o` is 0 whatever the other inputs do. The sequencing phase stays 0 in that time.
- R2: Once enabled, each leg's lower gate is the inverse of its upper gate. For cell c, bit 4c+1 = ~bit 4c and bit 4c+3 = ~bit 4c+2.
- R3: With the sequencing phase at 0, leg A upper (bit 4c) equals `ref_pos_i` and leg B upper (bit 4c+2) equals the inverse of `pwm_i[c]`.
- R4: Once enabled, a clock edge that samples `ref_pos_i` high, when the previous edge sampled it low, inverts the sequencing phase. The new mapping applies right after that edge.
- R5: Edges with the sign held high, falling zero crossings and repeated strobes leave the sequencing phase unchanged.
- R6: With the sequencing phase at 1, leg A upper equals `pwm_i[c]` and leg B upper equals the inverse of `ref_pos_i`.
- R7: In either phase, a cell drives +V (leg A up, leg B down) exactly when `ref_pos_i`=1 and `pwm_i[c]`=1. It drives -V (leg A down, leg B up) exactly when `ref_pos_i`=0 and `pwm_i[c]`=0.
- R8: All cells share one sequencing phase and one reference sign, and each cell uses only its own PWM bit.
- R9: A rising edge of the sign that happens before the enabling strobe does not toggle the phase, even if the sign stays high after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pos_i | input | 1 | Reference sign, 1 in the positive half cycle |
| period_stb_i | input | 1 | Fundamental-period strobe, enables the gates |
| pwm_i | input | NUM_CELLS | Carrier-comparison PWM bit per cell |
| gate_o | output | 4*NUM_CELLS | Gates per cell: leg A upper, leg A lower, leg B upper, leg B lower |

## Verification
The checks assume that `ref_pos_i`, `period_stb_i` and `pwm_i` change only between clock edges and stay stable around the rising edge. They also assume that the reference sign stays put for several clocks at a time, as a real zero-crossing signal would. The stimulus changes all inputs on the falling edge. It holds the sign for random runs, flipping it with a probability of one in eight per clock, and raises the strobe only occasionally. Directed sequences cover a sign that is already high at enable, strobes repeated while running, and falling crossings.

// File: rtl/hmc_pkg.sv
package hmc_pkg;
  localparam int unsigned GATES_PER_CELL = 4;

  // bit0 = leg A upper, bit1 = leg A lower, bit2 = leg B upper, bit3 = leg B lower
  typedef struct packed {
    logic lo_b;
    logic hi_b;
    logic lo_a;
    logic hi_a;
  } cell_gate_t;
endpackage

// File: rtl/hmc_seq_pulse.sv
module hmc_seq_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sign_i,
  input  logic stb_i,
  output logic phase_o,
  output logic en_o,
  output logic sign_q_o
);
  logic sign_q, en_q, phase_q;
  logic rise;

  assign rise = sign_i & ~sign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sign_q  <= 1'b0;
      en_q    <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      sign_q <= sign_i;
      if (stb_i) en_q <= 1'b1;
      // toggle only once running, on a rising zero crossing
      if (en_q && rise) phase_q <= ~phase_q;
    end
  end

  assign phase_o  = phase_q;
  assign en_o     = en_q;
  assign sign_q_o = sign_q;
endmodule

// File: rtl/hmc_leg.sv
module hmc_leg (
  input  logic en_i,
  input  logic cmd_i,
  output logic hi_o,
  output logic lo_o
);
  assign hi_o = en_i & cmd_i;
  assign lo_o = en_i & ~cmd_i;
endmodule

// File: rtl/hmc_cell_map.sv
module hmc_cell_map
  import hmc_pkg::*;
(
  input  logic       en_i,
  input  logic       phase_i,
  input  logic       fund_i,
  input  logic       pwm_i,
  output cell_gate_t gate_o
);
  logic cmd_a, cmd_b;

  // phase 1: leg A carries PWM, leg B carries the fundamental
  // phase 0: roles swap; leg B inverted so the cell level is unchanged
  assign cmd_a = phase_i ? pwm_i : fund_i;
  assign cmd_b = phase_i ? ~fund_i : ~pwm_i;

  hmc_leg i_leg_a (
    .en_i (en_i),
    .cmd_i(cmd_a),
    .hi_o (gate_o.hi_a),
    .lo_o (gate_o.lo_a)
  );

  hmc_leg i_leg_b (
    .en_i (en_i),
    .cmd_i(cmd_b),
    .hi_o (gate_o.hi_b),
    .lo_o (gate_o.lo_b)
  );
endmodule

// File: rtl/hybrid_mod_ctrl.sv
module hybrid_mod_ctrl
  import hmc_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                ref_pos_i,
  input  logic                                period_stb_i,
  input  logic [NUM_CELLS-1:0]                pwm_i,
  output logic [NUM_CELLS*GATES_PER_CELL-1:0] gate_o
);
  localparam int unsigned GATE_W = NUM_CELLS * GATES_PER_CELL;

  logic seq_phase, seq_en, sign_q;
  cell_gate_t cell_gate [NUM_CELLS];

  hmc_seq_pulse i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sign_i  (ref_pos_i),
    .stb_i   (period_stb_i),
    .phase_o (seq_phase),
    .en_o    (seq_en),
    .sign_q_o(sign_q)
  );

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    hmc_cell_map i_map (
      .en_i   (seq_en),
      .phase_i(seq_phase),
      .fund_i (ref_pos_i),
      .pwm_i  (pwm_i[c]),
      .gate_o (cell_gate[c])
    );
    assign gate_o[c*GATES_PER_CELL +: GATES_PER_CELL] = cell_gate[c];
  end

  logic [GATE_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/hybrid_mod_ctrl_chk.sv
module hybrid_mod_ctrl_chk #(
  parameter int unsigned NUM_CELLS = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   ref_pos_i,
  input logic                   period_stb_i,
  input logic [NUM_CELLS-1:0]   pwm_i,
  input logic [NUM_CELLS*4-1:0] gate_o,
  input logic                   seq_phase,
  input logic                   seq_en,
  input logic                   sign_q
);
  // R1 idle until enabled
  assert_idle_gates_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_en |-> (gate_o == '0) && !seq_phase);

  assert_enable_by_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_en) |-> $past(period_stb_i));

  // R4 toggle on rising crossing
  assert_phase_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_en && ref_pos_i && !sign_q) |=> (seq_phase != $past(seq_phase)));

  // R5 / R9 hold otherwise
  assert_phase_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seq_en && ref_pos_i && !sign_q) |=> $stable(seq_phase));

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
    assert_leg_compl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seq_en |-> (gate_o[4*c+1] != gate_o[4*c]) && (gate_o[4*c+3] != gate_o[4*c+2]));

    assert_pos_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seq_en |-> ((gate_o[4*c] & ~gate_o[4*c+2]) == (ref_pos_i & pwm_i[c])));

    assert_neg_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seq_en |-> ((~gate_o[4*c] & gate_o[4*c+2]) == (~ref_pos_i & ~pwm_i[c])));
  end
endmodule

bind hybrid_mod_ctrl hybrid_mod_ctrl_chk #(.NUM_CELLS(NUM_CELLS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_pos_i   (ref_pos_i),
  .period_stb_i(period_stb_i),
  .pwm_i       (pwm_i),
  .gate_o      (gate_o),
  .seq_phase   (seq_phase),
  .seq_en      (seq_en),
  .sign_q      (sign_q)
);

// File: tb/test_hybrid_mod_ctrl.sv
module test_hybrid_mod_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int GW = 4 * N;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_pos_i = 1'b0;
  logic period_stb_i = 1'b0;
  logic [N-1:0] pwm_i = '0;
  logic [GW-1:0] gate_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model
  bit m_phase = 0, m_en = 0, m_sign = 0;

  hybrid_mod_ctrl #(.NUM_CELLS(N)) i_hybrid_mod_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_pos_i(ref_pos_i),
    .period_stb_i(period_stb_i), .pwm_i(pwm_i), .gate_o(gate_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [GW-1:0] exp_gates(bit en, bit ph, logic r, logic [N-1:0] p);
    logic [GW-1:0] g;
    g = '0;
    if (en) begin
      for (int c = 0; c < N; c++) begin
        logic ha, hb;
        ha = ph ? p[c] : r;
        hb = ph ? ~r : ~p[c];
        g[4*c+0] = ha; g[4*c+1] = ~ha;
        g[4*c+2] = hb; g[4*c+3] = ~hb;
      end
    end
    return g;
  endfunction

  task automatic check(bit ok, string tag, logic [GW-1:0] act, logic [GW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_out();
    logic [GW-1:0] e;
    string tag;
    e = exp_gates(m_en, m_phase, ref_pos_i, pwm_i);
    tag = !m_en ? "R1" : (m_phase ? "R6" : "R3");
    check(gate_o === e, tag, gate_o, e);
    if (m_en) begin
      for (int c = 0; c < N; c++) begin
        bit comp, pos, neg;
        comp = (gate_o[4*c+1] == ~gate_o[4*c]) && (gate_o[4*c+3] == ~gate_o[4*c+2]);
        check(comp, "R2", gate_o, e);
        pos = (gate_o[4*c] & ~gate_o[4*c+2]) == (ref_pos_i & pwm_i[c]);
        neg = (~gate_o[4*c] & gate_o[4*c+2]) == (~ref_pos_i & ~pwm_i[c]);
        check(pos && neg, "R7", gate_o, e);
      end
    end
  endtask

  task automatic step(logic r, logic s, logic [N-1:0] p);
    @(negedge clk_i);
    ref_pos_i = r; period_stb_i = s; pwm_i = p;
    #1 check_out();
    @(posedge clk_i);
    if (m_en && r && !m_sign) m_phase = ~m_phase;
    m_sign = r;
    if (s) m_en = 1;
  endtask

  // probe phase at the ports: pwm all 0, sign forced high briefly between edges
  task automatic probe_phase(bit exp_ph, string tag);
    logic r0;
    logic [N-1:0] p0;
    @(negedge clk_i);
    r0 = ref_pos_i; p0 = pwm_i;
    ref_pos_i = 1'b1; pwm_i = '0;
    #1;
    n_chk++;
    if (gate_o[0] !== ~exp_ph) begin
      n_fail++;
      $display("FAIL %s: actual phase %0d expected %0d", tag, ~gate_o[0], exp_ph);
    end
    ref_pos_i = r0; pwm_i = p0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1 during reset
    ref_pos_i = 1; pwm_i = '1; period_stb_i = 1;
    #(CLK_PERIOD*2 + 1);
    check(gate_o === '0, "R1", gate_o, '0);
    period_stb_i = 0;
    @(negedge clk_i) rst_ni = 1'b1;
    // R1/R9: sign already high, no strobe yet
    repeat (4) step(1, 0, 3'b101);
    step(1, 1, 3'b011);               // enabling strobe
    repeat (3) step(1, 0, 3'b110);    // R9: no toggle while held high
    probe_phase(0, "R9");
    repeat (3) step(0, 0, 3'b001);
    step(1, 0, 3'b010);               // R4 rising edge
    probe_phase(1, "R4");
    repeat (3) step(1, 0, 3'b111);
    probe_phase(1, "R5");
    step(0, 0, 3'b000);               // falling crossing
    step(0, 1, 3'b100);               // repeated strobe
    probe_phase(1, "R5");
    step(1, 0, 3'b101);               // R4 back to phase 0
    probe_phase(0, "R4");
    // R8: distinct per-cell patterns, both phases
    step(1, 0, 3'b001); step(1, 0, 3'b010); step(0, 0, 3'b100);
    step(1, 0, 3'b110); step(1, 0, 3'b011);
    // random run
    for (int i = 0; i < 4000; i++) begin
      logic r;
      r = ref_pos_i;
      if ($urandom_range(7) == 0) r = ~r;
      step(r, $urandom_range(39) == 0, N'($urandom));
    end
    // R1 again after a mid-run reset
    @(negedge clk_i) rst_ni = 1'b0;
    m_en = 0; m_phase = 0; m_sign = 0;
    #1 check(gate_o === '0, "R1", gate_o, '0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) step(1, 0, 3'b111);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule